// File: doc/BRIEF.md
# Outstanding Request Age Watchdog

This block watches a small table of pending memory requests and raises an alarm when one of them has been waiting too long. A companion tracker owns the table. For each slot it supplies a valid bit and the time the request was issued. The tracker reads that time from the watchdog's own free-running cycle counter. The table has a read half and a write half of equal size.

The watchdog sleeps until a request is inserted. It then waits one threshold period and walks the table, one slot per cycle: read slots first, then write slots, each half in ascending index order. At each visit it compares the slot's age against the threshold. The first slot found at or beyond the limit sets a sticky alarm and captures which slot it was and how old it was. At the start of every walk the watchdog also compares the tracker's outstanding count with the number of valid slots. When the walk ends, the watchdog sleeps again if nothing is outstanding. Otherwise it schedules the next walk one full period later.

Top module: `age_watchdog`

## Requirements
- R1: The `now` counter reads 0 while reset is held. It increases by one each clock after reset and wraps modulo 2^TS_W.
- R2: After reset, `armed`, `deadlock` and `cnt_err` are all 0.
- R3: `ins_evt` sampled high while idle arms the watchdog. The first walk visits slot 0 in the cycle that follows the THRESH-th edge after the insert edge.
- R4: A walk takes 2*ENTRIES cycles, one slot per cycle. Slots 0..ENTRIES-1 are read entries 0..ENTRIES-1. Slots ENTRIES..2*ENTRIES-1 are write entries 0..ENTRIES-1.
- R5: A visited slot is an offender when it is valid and its age is at least THRESH. Age is `now` minus the stamp, modulo 2^TS_W, taken in the visit cycle. Invalid slots and younger slots are skipped.
- R6: The first offender sets `deadlock` on the edge that ends its visit cycle. That edge also latches `dl_wr` (0 for read, 1 for write), `dl_index` and `dl_age`. All four values hold until reset, and later offenders are ignored.
- R7: The walk ends on the edge after the last slot. If `outstanding` is non-zero at that point, the period timer restarts from zero and the next walk follows THRESH edges later. Otherwise `armed` drops to 0.
- R8: In the slot-0 cycle of each walk, `outstanding` is compared with the number of valid read and write slots. A mismatch sets `cnt_err` on the next edge, and `cnt_err` stays set until reset.
- R9: `ins_evt` while already armed does not move the schedule.
- R10: An age taken across a wrap of `now` is computed modularly, so a young entry is not flagged after the counter wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_evt | input | 1 | A request was inserted this cycle |
| rd_valid | input | ENTRIES | Read slot valid bits |
| rd_stamp | input | ENTRIES*TS_W | Read slot issue times, slot i at bits [i*TS_W +: TS_W] |
| wr_valid | input | ENTRIES | Write slot valid bits |
| wr_stamp | input | ENTRIES*TS_W | Write slot issue times, same packing |
| outstanding | input | CNT_W | Tracker's outstanding request count |
| now | output | TS_W | Free-running time counter |
| armed | output | 1 | Waiting for or performing a walk |
| deadlock | output | 1 | Sticky age alarm |
| dl_wr | output | 1 | Class of the captured offender (1 = write) |
| dl_index | output | IDX_W | Index of the captured offender |
| dl_age | output | TS_W | Age of the captured offender at its visit |
| cnt_err | output | 1 | Sticky count mismatch flag |

## Verification
The bound checker enforces several rules on every cycle. Once set, the alarm and the count error never clear. The captured slot data never changes while the alarm is set. A rising alarm always carries an age at or above the threshold. An insert while idle always arms the watchdog, and an idle watchdog never changes its alarm. Some behaviour only the bench scenarios can show: the exact edge where a walk starts and ends, the read-then-write visit order, which offender wins, the timer restart after a walk, and ages computed across a counter wrap.

// File: rtl/aw_pkg.sv
package aw_pkg;
   typedef enum logic [1:0] {
      AW_IDLE = 2'd0,
      AW_WAIT = 2'd1,
      AW_SCAN = 2'd2
   } aw_state_e;
endpackage

// File: rtl/aw_sched.sv
module aw_sched
   import aw_pkg::*;
#(
   parameter int THRESH = 20,
   parameter int SLOTS  = 8,
   localparam int TMR_W  = $clog2(THRESH) + 1,
   localparam int SLOT_W = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ins_evt,
   input  logic              busy_nz,
   output logic              armed,
   output logic              scan_act,
   output logic [SLOT_W-1:0] slot
);
   aw_state_e         state;
   logic [TMR_W-1:0]  timer;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= AW_IDLE;
         timer <= '0;
         slot  <= '0;
      end else begin
         unique case (state)
            AW_IDLE: begin
               if (ins_evt) begin
                  state <= AW_WAIT;
                  timer <= '0;
               end
            end
            AW_WAIT: begin
               if (timer == TMR_W'(THRESH - 1)) begin
                  state <= AW_SCAN;
                  slot  <= '0;
               end else begin
                  timer <= timer + 1'b1;
               end
            end
            AW_SCAN: begin
               if (slot == SLOT_W'(SLOTS - 1)) begin
                  state <= busy_nz ? AW_WAIT : AW_IDLE;
                  timer <= '0;
               end else begin
                  slot <= slot + 1'b1;
               end
            end
            default: state <= AW_IDLE;
         endcase
      end
   end

   assign armed    = (state != AW_IDLE);
   assign scan_act = (state == AW_SCAN);
endmodule

// File: rtl/aw_slot_eval.sv
module aw_slot_eval #(
   parameter int SLOTS  = 8,
   parameter int TS_W   = 16,
   parameter int THRESH = 20
) (
   input  logic [TS_W-1:0]             now,
   input  logic [SLOTS-1:0]            valid,
   input  logic [SLOTS-1:0][TS_W-1:0]  stamp,
   output logic [SLOTS-1:0][TS_W-1:0]  age,
   output logic [SLOTS-1:0]            over
);
   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      assign age[s]  = now - stamp[s];
      assign over[s] = valid[s] && (age[s] >= TS_W'(THRESH));
   end
endmodule

// File: rtl/age_watchdog.sv
module age_watchdog #(
   parameter int ENTRIES = 4,
   parameter int TS_W    = 16,
   parameter int THRESH  = 20,
   localparam int SLOTS  = 2 * ENTRIES,
   localparam int SLOT_W = $clog2(SLOTS),
   localparam int IDX_W  = $clog2(ENTRIES),
   localparam int CNT_W  = $clog2(SLOTS + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ins_evt,
   input  logic [ENTRIES-1:0]      rd_valid,
   input  logic [ENTRIES*TS_W-1:0] rd_stamp,
   input  logic [ENTRIES-1:0]      wr_valid,
   input  logic [ENTRIES*TS_W-1:0] wr_stamp,
   input  logic [CNT_W-1:0]        outstanding,
   output logic [TS_W-1:0]         now,
   output logic                    armed,
   output logic                    deadlock,
   output logic                    dl_wr,
   output logic [IDX_W-1:0]        dl_index,
   output logic [TS_W-1:0]         dl_age,
   output logic                    cnt_err
);
   if (THRESH < 1) begin : g_bad_thresh
      $error("THRESH must be at least 1");
   end
   if (THRESH >= (1 << TS_W)) begin : g_bad_width
      $error("THRESH must fit below 2**TS_W");
   end
   if (ENTRIES < 2) begin : g_bad_entries
      $error("ENTRIES must be at least 2");
   end

   logic [SLOTS-1:0]           all_valid;
   logic [SLOTS-1:0][TS_W-1:0] all_stamp;
   logic [SLOTS-1:0][TS_W-1:0] age;
   logic [SLOTS-1:0]           over;
   logic                       scan_act;
   logic [SLOT_W-1:0]          slot;
   logic                       sel_wr;
   logic [IDX_W-1:0]           sel_idx;
   logic [CNT_W-1:0]           valid_cnt;

   assign all_valid = {wr_valid, rd_valid};
   for (genvar i = 0; i < ENTRIES; i++) begin : g_pack
      assign all_stamp[i]           = rd_stamp[i*TS_W +: TS_W];
      assign all_stamp[i + ENTRIES] = wr_stamp[i*TS_W +: TS_W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) now <= '0;
      else        now <= now + 1'b1;
   end

   aw_sched #(.THRESH(THRESH), .SLOTS(SLOTS)) u_sched (
      .clk      (clk),
      .rst_n    (rst_n),
      .ins_evt  (ins_evt),
      .busy_nz  (outstanding != '0),
      .armed    (armed),
      .scan_act (scan_act),
      .slot     (slot)
   );

   aw_slot_eval #(.SLOTS(SLOTS), .TS_W(TS_W), .THRESH(THRESH)) u_eval (
      .now   (now),
      .valid (all_valid),
      .stamp (all_stamp),
      .age   (age),
      .over  (over)
   );

   assign sel_wr  = (slot >= SLOT_W'(ENTRIES));
   assign sel_idx = sel_wr ? IDX_W'(slot - SLOT_W'(ENTRIES)) : IDX_W'(slot);

   always_comb begin
      valid_cnt = '0;
      for (int i = 0; i < SLOTS; i++) valid_cnt = valid_cnt + CNT_W'(all_valid[i]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         deadlock <= 1'b0;
         dl_wr    <= 1'b0;
         dl_index <= '0;
         dl_age   <= '0;
         cnt_err  <= 1'b0;
      end else begin
         if (scan_act && !deadlock && over[slot]) begin
            deadlock <= 1'b1;
            dl_wr    <= sel_wr;
            dl_index <= sel_idx;
            dl_age   <= age[slot];
         end
         if (scan_act && (slot == '0) && (outstanding != valid_cnt))
            cnt_err <= 1'b1;
      end
   end
endmodule

// File: rtl/aw_chk.sv
module aw_chk #(
   parameter int ENTRIES = 4,
   parameter int TS_W    = 16,
   parameter int THRESH  = 20,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ins_evt,
   input logic             armed,
   input logic             deadlock,
   input logic             dl_wr,
   input logic [IDX_W-1:0] dl_index,
   input logic [TS_W-1:0]  dl_age,
   input logic             cnt_err
);
   p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      deadlock |=> deadlock);
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      deadlock |=> ($stable(dl_wr) && $stable(dl_index) && $stable(dl_age)));
   p_age_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(deadlock) |-> (dl_age >= TS_W'(THRESH)));
   p_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed && ins_evt) |=> armed);
   p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |=> $stable(deadlock));
   p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_err |=> cnt_err);
endmodule

bind age_watchdog aw_chk #(.ENTRIES(ENTRIES), .TS_W(TS_W), .THRESH(THRESH)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ins_evt  (ins_evt),
   .armed    (armed),
   .deadlock (deadlock),
   .dl_wr    (dl_wr),
   .dl_index (dl_index),
   .dl_age   (dl_age),
   .cnt_err  (cnt_err)
);

// File: tb/age_watchdog_bench.sv
module age_watchdog_bench;
   localparam int E  = 4;
   localparam int TW = 8;
   localparam int TH = 20;
   localparam int IW = $clog2(E);
   localparam int CW = $clog2(2*E + 1);

   logic            clk = 1'b0;
   logic            rst_n;
   logic            ins_evt;
   logic [E-1:0]    rd_valid, wr_valid;
   logic [E*TW-1:0] rd_stamp, wr_stamp;
   logic [CW-1:0]   outstanding;
   logic [TW-1:0]   now;
   logic            armed, deadlock, dl_wr, cnt_err;
   logic [IW-1:0]   dl_index;
   logic [TW-1:0]   dl_age;

   logic [TW-1:0] st_r [E];
   logic [TW-1:0] st_w [E];
   logic [TW-1:0] now_ins;
   int n_chk = 0;
   int n_err = 0;
   bit done = 0;

   always #5 clk = ~clk;

   always_comb begin
      for (int i = 0; i < E; i++) begin
         rd_stamp[i*TW +: TW] = st_r[i];
         wr_stamp[i*TW +: TW] = st_w[i];
      end
   end

   age_watchdog #(.ENTRIES(E), .TS_W(TW), .THRESH(TH)) u_age_watchdog (
      .clk(clk), .rst_n(rst_n), .ins_evt(ins_evt),
      .rd_valid(rd_valid), .rd_stamp(rd_stamp),
      .wr_valid(wr_valid), .wr_stamp(wr_stamp),
      .outstanding(outstanding), .now(now), .armed(armed),
      .deadlock(deadlock), .dl_wr(dl_wr), .dl_index(dl_index),
      .dl_age(dl_age), .cnt_err(cnt_err)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic eq(input string req, input longint act, input longint exp);
      chk(act == exp, req, act, exp);
   endtask

   task automatic waitn(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; ins_evt = 1'b0;
      rd_valid = '0; wr_valid = '0; outstanding = '0;
      for (int i = 0; i < E; i++) begin st_r[i] = '0; st_w[i] = '0; end
      waitn(3);
      rst_n = 1'b1;
   endtask

   task automatic insert();
      now_ins = now;
      ins_evt = 1'b1;
      @(negedge clk);
      ins_evt = 1'b0;
   endtask

   function automatic void expect_scan(input logic [TW-1:0] t0, output bit found,
                                       output bit wr, output int idx, output int age);
      found = 0; wr = 0; idx = 0; age = 0;
      for (int s = 0; s < 2*E; s++) begin
         bit v; logic [TW-1:0] st; logic [TW-1:0] a;
         v  = (s < E) ? rd_valid[s] : wr_valid[s-E];
         st = (s < E) ? st_r[s] : st_w[s-E];
         a  = t0 + TW'(1 + TH + s) - st;
         if (!found && v && a >= TW'(TH)) begin
            found = 1; wr = (s >= E); idx = s % E; age = int'(a);
         end
      end
   endfunction

   task automatic run_tests();
      bit f, w; int ix, ag;
      // R1, R2: reset state and counter
      do_reset();
      eq("R1 now at reset", now, 0);
      eq("R2 armed after reset", armed, 0);
      eq("R2 deadlock after reset", deadlock, 0);
      eq("R2 cnt_err after reset", cnt_err, 0);
      waitn(1);
      eq("R1 now after one edge", now, 1);
      waitn(299);
      eq("R1 now wraps", now, 300 % 256);

      // R3, R5 boundary: read 0 age exactly TH at visit
      do_reset(); waitn(7);
      rd_valid = 4'b0001; outstanding = 1;
      st_r[0] = now + 8'd1;
      insert();
      waitn(TH);
      eq("R3 no flag before slot0 visit ends", deadlock, 0);
      waitn(1);
      eq("R3 flag after slot0 visit", deadlock, 1);
      eq("R5 age at boundary", dl_age, TH);
      eq("R6 read class", dl_wr, 0);
      eq("R6 index 0", dl_index, 0);

      // R4, R5: only write 3 offends; read 0 just below limit
      do_reset(); waitn(3);
      rd_valid = 4'b0001; wr_valid = 4'b1000; outstanding = 2;
      st_r[0] = now + 8'd2;
      st_w[3] = now + 8'd8;
      insert();
      waitn(TH + 7);
      eq("R4 R5 no flag before last slot", deadlock, 0);
      waitn(1);
      eq("R4 flag at last slot", deadlock, 1);
      eq("R4 write class", dl_wr, 1);
      eq("R4 write index", dl_index, 3);
      eq("R5 write age", dl_age, TH);

      // R6: first offender wins and holds
      do_reset();
      rd_valid = 4'b0100; wr_valid = 4'b0001; outstanding = 2;
      st_r[2] = now - 8'd10; st_w[0] = now - 8'd40;
      insert();
      waitn(TH + 2*E);
      expect_scan(now_ins, f, w, ix, ag);
      eq("R6 first offender index", dl_index, ix);
      eq("R6 first offender class", dl_wr, w);
      eq("R6 first offender age", dl_age, ag);
      st_r[2] = now - 8'd90;
      waitn(TH + 2*E + 2);
      eq("R6 held index", dl_index, ix);
      eq("R6 held age", dl_age, ag);

      // R7, R9: empty table, second insert while armed
      do_reset(); waitn(2);
      insert();
      waitn(5); ins_evt = 1'b1; @(negedge clk); ins_evt = 1'b0;
      waitn(TH + 2*E - 1 - 6);
      eq("R9 still armed before walk end", armed, 1);
      waitn(1);
      eq("R7 R9 idle after walk end", armed, 0);

      // R7: re-arm and timer restart
      do_reset(); waitn(4);
      rd_valid = 4'b0001; outstanding = 1;
      st_r[0] = now + 8'd1 + 8'(TH) - 8'd10;
      insert();
      waitn(TH + 2*E + 1);
      eq("R7 rearmed", armed, 1);
      eq("R7 no flag first walk", deadlock, 0);
      waitn(TH - 1);
      eq("R7 no flag before second slot0", deadlock, 0);
      waitn(1);
      eq("R7 flag in second walk", deadlock, 1);
      eq("R7 second walk age", dl_age, 10 + TH + 2*E);
      rd_valid = '0; outstanding = 0;
      waitn(2*E);
      eq("R7 idle after empty walk", armed, 0);

      // R8: count mismatch
      do_reset();
      rd_valid = 4'b0010; outstanding = 3; st_r[1] = now;
      insert();
      waitn(TH);
      eq("R8 no error before slot0 ends", cnt_err, 0);
      waitn(1);
      eq("R8 mismatch flagged", cnt_err, 1);
      outstanding = 1;
      waitn(TH + 2*E);
      eq("R8 error sticky", cnt_err, 1);

      // R10: wrap
      do_reset();
      while (now != 8'd250) @(negedge clk);
      rd_valid = 4'b0011; outstanding = 2;
      st_r[0] = 8'd255; st_r[1] = 8'd250;
      insert();
      waitn(TH + 2*E);
      eq("R10 young entry not flagged across wrap", dl_index, 1);
      eq("R10 age across wrap", dl_age, 22);

      // random trials
      for (int t = 0; t < 40; t++) begin
         do_reset();
         waitn($urandom_range(0, 300));
         rd_valid = E'($urandom); wr_valid = E'($urandom);
         outstanding = CW'($countones({wr_valid, rd_valid}));
         for (int i = 0; i < E; i++) begin
            st_r[i] = now + TW'($urandom_range(0, 30)) - 8'd12;
            st_w[i] = now + TW'($urandom_range(0, 30)) - 8'd12;
         end
         insert();
         waitn(TH + 2*E);
         expect_scan(now_ins, f, w, ix, ag);
         eq("R5 random flag", deadlock, f);
         if (f) begin
            eq("R6 random class", dl_wr, w);
            eq("R6 random index", dl_index, ix);
            eq("R5 random age", dl_age, ag);
         end
         eq("R8 random no count error", cnt_err, 0);
         eq("R7 random armed", armed, (outstanding != 0));
      end
   endtask

   initial begin
      void'($urandom(32'd1234));
      rst_n = 1'b0; ins_evt = 1'b0;
      rd_valid = '0; wr_valid = '0; outstanding = '0;
      for (int i = 0; i < E; i++) begin st_r[i] = '0; st_w[i] = '0; end
      fork
         run_tests();
         begin
            repeat (150000) @(posedge clk);
            n_chk++; n_err++;
            $display("FAIL watchdog actual=timeout expected=finish");
         end
      join_any
      disable fork;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule